// File: doc/BRIEF.md
# Grouped Serial Shift Register Bank

This block holds the working registers of a bit-serial datapath. It has eight registers, each of which moves one bit per clock. Every register has a serial output bit that feeds an external switch matrix, and takes a serial input bit back from that matrix. Register 0 is the top of stack and register 1 is the next on stack. Each of these two has its own direction. Registers 2 to 7 form one group that always moves together.

A 3-bit operation code from the microcode selects one of eight combinations of directions per clock. Code 1 is the exception. It moves nothing and instead loads two internal parallel registers, a constant register and a data register, from their parallel inputs.

A width-mode input sets the active register length to 32 bits or 16 bits. In 16-bit mode the upper half of every register is forced to zero, and the serial boundary moves to bit 15. The parallel contents are brought out so that the surrounding logic can observe them.

Top module: `srf_bank`

## Requirements
- R1: After reset, all eight registers, the constant register and the data register read zero.
- R2: With code 0, no register changes (in 16-bit mode the upper half is still cleared).
- R3: With code 1, no shift register moves. The constant and data registers take `const_in` and `data_in`, masked to the active width. With any other code, both parallel registers keep their value.
- R4: Code 2 moves register 0 up and moves register 1 and registers 2..7 down.
- R5: Code 3 holds register 0 and moves register 1 and registers 2..7 up.
- R6: Code 4 moves all eight registers down.
- R7: Code 5 moves registers 0 and 1 down and holds registers 2..7.
- R8: Code 6 holds register 0 and moves register 1 and registers 2..7 down.
- R9: Code 7 moves registers 0 and 1 up and holds registers 2..7.
- R10: A downward move drops bit 0 and writes the register's serial input into the top active bit: bit 31 when `mode32`=1, bit 15 when `mode32`=0.
- R11: An upward move drops the top active bit and writes the serial input into bit 0. The result is masked to the active width.
- R12: After any clock edge taken with `mode32`=0, bits 31..16 of every register, of the constant register and of the data register are zero.
- R13: `ser_out[i]` is combinational from the current code. It shows the top active bit of register i when that register is moving up, and shows bit 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | 1 = 32-bit registers, 0 = 16-bit registers |
| op_code | input | 3 | Shift combination code (0..7) |
| ser_in | input | 8 | Serial input bit per register, bit i for register i |
| ser_out | output | 8 | Serial output bit per register, bit i for register i |
| const_in | input | 32 | Parallel value for the constant register |
| data_in | input | 32 | Parallel value for the data register |
| regs_q | output | 256 | Register contents, register i at bits i*32+31..i*32 |
| const_q | output | 32 | Constant register contents |
| data_q | output | 32 | Data register contents |

## Verification
The hardest case to reach is a drop from 32-bit to 16-bit mode while the upper halves hold live data. A downward move at that moment must not let bit 16 leak into bit 15, and the serial output must switch at once to the new top bit. The sweep reaches this case by running every code in 32-bit mode with a pseudo-random serial stream, which fills all upper halves, and then repeating every code in 16-bit mode. A short directed test then checks where the serial input lands at each width.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    MV_HOLD = 2'd0,
    MV_DOWN = 2'd1,
    MV_UP   = 2'd2
  } move_e;

  typedef struct packed {
    move_e tos;
    move_e nos;
    move_e rest;
    logic  load;
  } plan_t;

  // Map a microcode shift code onto per-group directions.
  function automatic plan_t decode_op(input logic [2:0] code);
    plan_t p;
    p.tos  = MV_HOLD;
    p.nos  = MV_HOLD;
    p.rest = MV_HOLD;
    p.load = 1'b0;
    case (code)
      3'd1: p.load = 1'b1;
      3'd2: begin p.tos = MV_UP;   p.nos = MV_DOWN; p.rest = MV_DOWN; end
      3'd3: begin                  p.nos = MV_UP;   p.rest = MV_UP;   end
      3'd4: begin p.tos = MV_DOWN; p.nos = MV_DOWN; p.rest = MV_DOWN; end
      3'd5: begin p.tos = MV_DOWN; p.nos = MV_DOWN;                   end
      3'd6: begin                  p.nos = MV_DOWN; p.rest = MV_DOWN; end
      3'd7: begin p.tos = MV_UP;   p.nos = MV_UP;                     end
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/srf_op_decode.sv
module srf_op_decode
  import srf_pkg::*;
(
  input  logic [2:0] op_code,
  output move_e      tos_mv,
  output move_e      nos_mv,
  output move_e      rest_mv,
  output logic       load_en
);
  plan_t plan;

  always_comb begin
    plan    = decode_op(op_code);
    tos_mv  = plan.tos;
    nos_mv  = plan.nos;
    rest_mv = plan.rest;
    load_en = plan.load;
  end
endmodule

// File: rtl/srf_lane.sv
module srf_lane
  import srf_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode32,
  input  move_e        mv,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);
  localparam int H = W / 2;
  localparam logic [W-1:0] FULL_M = {W{1'b1}};
  localparam logic [W-1:0] HALF_M = {{(W-H){1'b0}}, {H{1'b1}}};

  function automatic logic [W-1:0] width_mask(input logic m32);
    return m32 ? FULL_M : HALF_M;
  endfunction

  function automatic logic top_bit(input logic [W-1:0] v, input logic m32);
    return m32 ? v[W-1] : v[H-1];
  endfunction

  function automatic logic [W-1:0] step(input logic [W-1:0] v, input move_e d,
                                        input logic b, input logic m32);
    logic [W-1:0] r;
    case (d)
      MV_DOWN: begin
        r = v >> 1;
        if (m32) r[W-1] = b;
        else     r[H-1] = b;
      end
      MV_UP:   r = {v[W-2:0], b};
      default: r = v;
    endcase
    return r & width_mask(m32);
  endfunction

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = step(q, mv, sin, mode32);
    sout  = (mv == MV_UP) ? top_bit(q, mode32) : q[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/srf_preg.sv
module srf_preg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode32,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  localparam int H = W / 2;
  localparam logic [W-1:0] HALF_M = {{(W-H){1'b0}}, {H{1'b1}}};

  logic [W-1:0] mask;
  assign mask = mode32 ? {W{1'b1}} : HALF_M;

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din & mask;
    else           q <= q & mask;
  end
endmodule

// File: rtl/srf_bank.sv
module srf_bank
  import srf_pkg::*;
#(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode32,
  input  logic [2:0]        op_code,
  input  logic [NREG-1:0]   ser_in,
  output logic [NREG-1:0]   ser_out,
  input  logic [W-1:0]      const_in,
  input  logic [W-1:0]      data_in,
  output logic [NREG*W-1:0] regs_q,
  output logic [W-1:0]      const_q,
  output logic [W-1:0]      data_q
);
  // Named decode results, visible to the checker.
  move_e tos_mv, nos_mv, rest_mv;
  logic  load_en;

  srf_op_decode dec_i (
    .op_code (op_code),
    .tos_mv  (tos_mv),
    .nos_mv  (nos_mv),
    .rest_mv (rest_mv),
    .load_en (load_en)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_lane
    move_e lane_mv;
    if (i == 0)      begin : g_tos  assign lane_mv = tos_mv;  end
    else if (i == 1) begin : g_nos  assign lane_mv = nos_mv;  end
    else             begin : g_rest assign lane_mv = rest_mv; end

    srf_lane #(.W(W)) lane_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode32 (mode32),
      .mv     (lane_mv),
      .sin    (ser_in[i]),
      .q      (regs_q[i*W +: W]),
      .sout   (ser_out[i])
    );
  end

  srf_preg #(.W(W)) const_i (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .load(load_en),
    .din(const_in), .q(const_q)
  );

  srf_preg #(.W(W)) data_i (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .load(load_en),
    .din(data_in), .q(data_q)
  );
endmodule

// File: rtl/srf_bank_chk.sv
module srf_bank_chk #(
  parameter int W    = 32,
  parameter int NREG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode32,
  input logic [2:0]        op_code,
  input logic [NREG-1:0]   ser_in,
  input logic [NREG-1:0]   ser_out,
  input logic [W-1:0]      const_in,
  input logic [W-1:0]      data_in,
  input logic [NREG*W-1:0] regs_q,
  input logic [W-1:0]      const_q,
  input logic [W-1:0]      data_q,
  input logic [1:0]        tos_mv,
  input logic [1:0]        nos_mv,
  input logic [1:0]        rest_mv,
  input logic              load_en
);
  localparam int H = W / 2;
  localparam logic [W-1:0] LOW_M = {{(W-H){1'b0}}, {H{1'b1}}};
  localparam logic [W-1:0] UP_M  = ~LOW_M;

  a_r2_hold_all: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd0 && mode32) |=> regs_q == $past(regs_q));

  a_r3_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (tos_mv == 2'd0 && nos_mv == 2'd0 && rest_mv == 2'd0));

  a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (const_q == ($past(mode32) ? $past(const_in) : ($past(const_in) & LOW_M)))
             && (data_q  == ($past(mode32) ? $past(data_in)  : ($past(data_in)  & LOW_M))));

  a_r3_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && mode32) |=> (const_q == $past(const_q) && data_q == $past(data_q)));

  a_r4_tos_up: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd2 && mode32) |=>
      regs_q[0 +: W] == {$past(regs_q[0 +: W-1]), $past(ser_in[0])});

  a_r6_rest_down: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd4 && mode32) |=>
      regs_q[2*W +: W] == {$past(ser_in[2]), $past(regs_q[2*W+1 +: W-1])});

  a_r7_rest_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 3'd5 && mode32) |=> $stable(regs_q[NREG*W-1:2*W]));

  a_r13_nos_up_out: assert property (@(posedge clk) disable iff (!rst_n)
    (nos_mv == 2'd2 && mode32) |-> ser_out[1] == regs_q[2*W-1]);

  a_r13_tos_down_out: assert property (@(posedge clk) disable iff (!rst_n)
    (tos_mv == 2'd1) |-> ser_out[0] == regs_q[0]);

  for (genvar i = 0; i < NREG; i++) begin : g_up
    a_r12_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mode32 |=> (regs_q[i*W +: W] & UP_M) == '0);
  end

  a_r12_preg_upper: assert property (@(posedge clk) disable iff (!rst_n)
    !mode32 |=> ((const_q & UP_M) == '0 && (data_q & UP_M) == '0));
endmodule

bind srf_bank srf_bank_chk #(.W(W), .NREG(NREG)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode32(mode32), .op_code(op_code),
  .ser_in(ser_in), .ser_out(ser_out), .const_in(const_in), .data_in(data_in),
  .regs_q(regs_q), .const_q(const_q), .data_q(data_q),
  .tos_mv(tos_mv), .nos_mv(nos_mv), .rest_mv(rest_mv), .load_en(load_en)
);

// File: tb/srf_bank_tb.sv
`timescale 1ns/1ps
module srf_bank_tb_top;
  localparam int W = 32;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           mode32 = 1'b1;
  logic [2:0]     op_code = 3'd0;
  logic [N-1:0]   ser_in = '0;
  logic [N-1:0]   ser_out;
  logic [W-1:0]   const_in = '0, data_in = '0;
  logic [N*W-1:0] regs_q;
  logic [W-1:0]   const_q, data_q;

  srf_bank #(.W(W), .NREG(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode32(mode32), .op_code(op_code),
    .ser_in(ser_in), .ser_out(ser_out), .const_in(const_in), .data_in(data_in),
    .regs_q(regs_q), .const_q(const_q), .data_q(data_q)
  );

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0;
  logic [31:0] mdl [N];
  logic [31:0] mc, md;
  logic [31:0] lfsr = 32'hACE1_2468;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lmask(input logic m);
    return m ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // direction per register for a code: 0 hold, 1 down, 2 up
  function automatic int dir_of(input int code, input int r);
    int t, n, g;
    t = 0; n = 0; g = 0;
    case (code)
      2: begin t = 2; n = 1; g = 1; end
      3: begin n = 2; g = 2; end
      4: begin t = 1; n = 1; g = 1; end
      5: begin t = 1; n = 1; end
      6: begin n = 1; g = 1; end
      7: begin t = 2; n = 2; end
      default: ;
    endcase
    return (r == 0) ? t : (r == 1) ? n : g;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x, input int d,
                                      input logic b, input logic m);
    int len;
    logic [31:0] k;
    len = m ? 32 : 16;
    k = lmask(m);
    if (d == 1) return ((x & k) >> 1) | (32'(b) << (len - 1));
    if (d == 2) return ((x << 1) | 32'(b)) & k;
    return x & k;
  endfunction

  task automatic step(input int code, input logic m, input logic [N-1:0] sin,
                      input logic [31:0] ci, input logic [31:0] di);
    logic [31:0] exp_r [N];
    string tag;
    @(negedge clk);
    op_code = 3'(code); mode32 = m; ser_in = sin; const_in = ci; data_in = di;
    #0.5;
    for (int r = 0; r < N; r++) begin
      int d;
      d = dir_of(code, r);
      chk("R13", {31'd0, ser_out[r]},
          {31'd0, (d == 2) ? mdl[r][(m ? 32 : 16) - 1] : mdl[r][0]});
      exp_r[r] = nxt(mdl[r], d, sin[r], m);
    end
    if (code == 1) begin mc = ci & lmask(m); md = di & lmask(m); end
    else begin mc = mc & lmask(m); md = md & lmask(m); end
    @(posedge clk); #1;
    case (code)
      0: tag = "R2"; 1: tag = "R3"; 2: tag = "R4"; 3: tag = "R5";
      4: tag = "R6"; 5: tag = "R7"; 6: tag = "R8"; default: tag = "R9";
    endcase
    for (int r = 0; r < N; r++) begin
      mdl[r] = exp_r[r];
      chk(tag, regs_q[r*W +: W], mdl[r]);
      if (!m) chk("R12", regs_q[r*W +: W] & 32'hFFFF_0000, 32'h0);
    end
    chk("R3", const_q, mc);
    chk("R3", data_q, md);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; op_code = 3'd0;
    @(posedge clk); #1;
    for (int r = 0; r < N; r++) mdl[r] = '0;
    mc = '0; md = '0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  function automatic logic [31:0] roll(input logic [31:0] v);
    return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    for (int r = 0; r < N; r++) chk("R1", regs_q[r*W +: W], 32'h0);
    chk("R1", const_q, 32'h0);
    chk("R1", data_q, 32'h0);
    do_reset();

    // Sweep: both widths, every code, pseudo-random serial and parallel data.
    for (int pass = 0; pass < 3; pass++)
      for (int mi = 1; mi >= 0; mi--)
        for (int code = 0; code < 8; code++)
          for (int k = 0; k < 20; k++) begin
            lfsr = roll(lfsr);
            step(code, mi[0], lfsr[7:0], lfsr ^ 32'h5A5A_F00F, ~lfsr);
          end

    // R10: serial input lands at the top active bit on a downward move.
    do_reset();
    step(4, 1'b0, 8'hFF, 32'h0, 32'h0);
    chk("R10", regs_q[0 +: W], 32'h0000_8000);
    step(4, 1'b1, 8'hFF, 32'h0, 32'h0);
    chk("R10", regs_q[2*W +: W], 32'h8000_4000);

    // R11: upward moves fill from bit 0 and saturate at the active width.
    do_reset();
    for (int k = 0; k < 17; k++) step(7, 1'b0, 8'h03, 32'h0, 32'h0);
    chk("R11", regs_q[0 +: W], 32'h0000_FFFF);
    chk("R11", regs_q[W +: W], 32'h0000_FFFF);
    step(7, 1'b1, 8'h00, 32'h0, 32'h0);
    chk("R11", regs_q[0 +: W], 32'h0001_FFFE);

    // R12: width drop with live upper halves clears them on a hold.
    step(1, 1'b1, 8'h00, 32'hDEAD_BEEF, 32'h1234_5678);
    step(0, 1'b0, 8'h00, 32'h0, 32'h0);
    chk("R12", const_q, 32'h0000_BEEF);
    chk("R12", data_q, 32'h0000_5678);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule